// File: doc/BRIEF.md
# Dual Performance Counter Unit

This block keeps two 32-bit event counters that software sees as the two halves of one 64-bit counter register, plus one control register that governs both of them. Each counter has its own 6-bit event code that picks one strobe out of a vector of event inputs. The counters share one set of privilege-context enables (user, supervisor, hypervisor). A counter advances by one in a cycle when its chosen strobe is high and the enable for the current privilege context is set.

When a counter wraps from all ones to zero, the unit latches an overflow flag for that counter. It raises an interrupt when the overflow interrupt enable is set. The flags show which counter overflowed, because a counter that software treats as idle can still run. Software parks an idle counter on event code 63, which never counts. For sampling, software preloads a counter with the two's complement of the period. Any write to the control register clears the latched flags.

Top module: `perf_counter_pair`

## Requirements
- R1: After reset, both counters, the control register, both overflow flags and the interrupt are zero.
- R2: The counter register (reg_sel=1) holds the upper counter (index 0) in bits 63:32 and the lower counter (index 1) in bits 31:0. A write loads only the halves whose wr_half bit is set (bit 1 selects the upper half, bit 0 the lower half). The other half keeps its value.
- R3: The control register (reg_sel=0) keeps these bits: supervisor enable at bit 1, user enable at bit 2, hypervisor enable at bit 3, interrupt enable at bit 4, the lower counter's event code at bits 16:11 and the upper counter's event code at bits 32:27. All other bits read as zero.
- R4: A counter increments by one in a cycle where event_in[code] is high and the enable bit for priv_ctx is set. The priv_ctx encoding is 0 user, 1 supervisor, 2 hypervisor, 3 none, and 3 never counts.
- R5: With user, supervisor and hypervisor enables all clear, neither counter changes except by a write.
- R6: Event code 63 never counts.
- R7: A write to a counter half takes priority over an increment of that counter in the same cycle.
- R8: An increment from 0xFFFFFFFF to 0 sets that counter's overflow flag (ovf_o[0] upper, ovf_o[1] lower). Loading a value by a write sets no flag.
- R9: irq_o is high exactly when the interrupt enable is set and at least one overflow flag is set.
- R10: Any control write clears both overflow flags. An overflow in the same cycle still sets its flag.
- R11: A counter preloaded with 2^32 - P overflows on the P-th counted event, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects the counter pair |
| wr_half | input | 2 | Counter half write enables: bit 1 upper, bit 0 lower |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data of the selected register |
| priv_ctx | input | 2 | Current privilege context |
| event_in | input | 63 | Event strobes, one per event code 0..62 |
| ovf_o | output | 2 | Latched overflow flags |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The hardest case to reach is a collision: a counter wraps in the same cycle as a control write, or in the same cycle as a write to the other counter half. With a full 32-bit range, random counting almost never reaches a wrap. The stimulus therefore often preloads counters to within a few counts of 0xFFFFFFFF, then issues random control writes and half writes while strobes toggle. Directed steps also place a control write exactly on the wrap cycle, and a write on a cycle where the strobe is high.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int CNT_W    = 32;
  localparam int NUM_CNT  = 2;
  localparam int EVT_W    = 6;
  localparam int NUM_EVT  = (1 << EVT_W) - 1;
  localparam int CTRL_W   = 33;
  localparam int B_SUP    = 1;
  localparam int B_USR    = 2;
  localparam int B_HYP    = 3;
  localparam int B_IEN    = 4;
  localparam int EV_LO_LSB = 11;
  localparam int EV_UP_LSB = 27;
  localparam logic [EVT_W-1:0] PARK_CODE = '1;

  typedef enum logic [1:0] {
    CTX_USR  = 2'd0,
    CTX_SUP  = 2'd1,
    CTX_HYP  = 2'd2,
    CTX_NONE = 2'd3
  } ctx_e;

  // Event field position for counter index (0 = upper, 1 = lower)
  function automatic int ev_lsb(input int idx);
    return (idx == 0) ? EV_UP_LSB : EV_LO_LSB;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    m[B_SUP] = 1'b1;
    m[B_USR] = 1'b1;
    m[B_HYP] = 1'b1;
    m[B_IEN] = 1'b1;
    m[EV_LO_LSB +: EVT_W] = '1;
    m[EV_UP_LSB +: EVT_W] = '1;
    return m;
  endfunction
endpackage

// File: rtl/pcu_ctx_gate.sv
module pcu_ctx_gate
  import pcu_pkg::*;
(
  input  logic       usr_en,
  input  logic       sup_en,
  input  logic       hyp_en,
  input  logic [1:0] ctx,
  output logic       cnt_en
);
  always_comb begin
    unique case (ctx)
      CTX_USR: cnt_en = usr_en;
      CTX_SUP: cnt_en = sup_en;
      CTX_HYP: cnt_en = hyp_en;
      default: cnt_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcu_counter.sv
module pcu_counter #(
  parameter int W       = 32,
  parameter int EW      = 6,
  parameter int NEVT    = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic [EW-1:0] evt_code,
  input  logic [NEVT-1:0] events,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_val,
  output logic [W-1:0]  cnt_q,
  output logic          wrap_o
);
  localparam int EXT = 1 << EW;
  localparam logic [EW-1:0] PARK = '1;

  logic [EXT-1:0] ev_ext;
  logic           hit;
  logic           ld;
  logic [W-1:0]   cnt_d;

  assign ev_ext = {{(EXT-NEVT){1'b0}}, events};
  assign hit    = cnt_en && (evt_code != PARK) && ev_ext[evt_code];
  assign wrap_o = hit && !wr_en && (&cnt_q);

  always_comb begin
    ld    = wr_en | hit;
    cnt_d = cnt_q;
    if (wr_en)    cnt_d = wr_val;
    else if (hit) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (ld) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pcu_ovf_latch.sv
module pcu_ovf_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_d;
  logic         ce;

  always_comb begin
    ce     = clr_i | (|set_i);
    flag_d = (clr_i ? '0 : flag_q) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flag_q <= '0;
    else if (ce) flag_q <= flag_d;
  end
endmodule

// File: rtl/perf_counter_pair.sv
module perf_counter_pair
  import pcu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [1:0]           wr_half,
  input  logic [63:0]          wr_data,
  output logic [63:0]          rd_data,
  input  logic [1:0]           priv_ctx,
  input  logic [NUM_EVT-1:0]   event_in,
  output logic [NUM_CNT-1:0]   ovf_o,
  output logic                 irq_o
);
  localparam logic [CTRL_W-1:0] CMASK = ctrl_mask();

  logic [CTRL_W-1:0]            ctrl_q;
  logic [CTRL_W-1:0]            ctrl_d;
  logic                         ctrl_wr;
  logic                         cnt_en;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CNT-1:0]           wrap;
  logic [NUM_CNT-1:0]           ovf_q;

  assign ctrl_wr = reg_wr && !reg_sel;

  always_comb begin
    ctrl_d = wr_data[CTRL_W-1:0] & CMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  pcu_ctx_gate u_gate (
    .usr_en (ctrl_q[B_USR]),
    .sup_en (ctrl_q[B_SUP]),
    .hyp_en (ctrl_q[B_HYP]),
    .ctx    (priv_ctx),
    .cnt_en (cnt_en)
  );

  // Index 0 is the upper half (63:32, wr_half[1]); index 1 the lower half
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int HALF = NUM_CNT - 1 - i;
    logic wr_en;
    assign wr_en = reg_wr && reg_sel && wr_half[HALF];
    pcu_counter #(.W(CNT_W), .EW(EVT_W), .NEVT(NUM_EVT)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_en   (cnt_en),
      .evt_code (ctrl_q[ev_lsb(i) +: EVT_W]),
      .events   (event_in),
      .wr_en    (wr_en),
      .wr_val   (wr_data[HALF*CNT_W +: CNT_W]),
      .cnt_q    (cnt_q[i]),
      .wrap_o   (wrap[i])
    );
  end

  pcu_ovf_latch #(.N(NUM_CNT)) u_ovf (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wrap),
    .clr_i  (ctrl_wr),
    .flag_q (ovf_q)
  );

  assign ovf_o   = ovf_q;
  assign irq_o   = ctrl_q[B_IEN] && (|ovf_q);
  assign rd_data = reg_sel ? {cnt_q[0], cnt_q[1]} : {{(64-CTRL_W){1'b0}}, ctrl_q};
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [1:0]        wr_half,
  input logic [63:0]       wr_data,
  input logic [1:0]        priv_ctx,
  input logic [32:0]       ctrl_q,
  input logic [1:0][31:0]  cnt_q,
  input logic [1:0]        ovf_q,
  input logic              irq_o
);
  logic wr_up, wr_lo, wr_ctl, gated_off;
  assign wr_up     = reg_wr && reg_sel && wr_half[1];
  assign wr_lo     = reg_wr && reg_sel && wr_half[0];
  assign wr_ctl    = reg_wr && !reg_sel;
  assign gated_off = (priv_ctx == 2'd3) || (ctrl_q[3:1] == 3'b000);

  AST_WR_PRIO_UP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_up |=> cnt_q[0] == $past(wr_data[63:32])); // R7
  AST_WR_PRIO_LO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt_q[1] == $past(wr_data[31:0])); // R7
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr && reg_sel) && gated_off) |=> $stable(cnt_q)); // R5
  AST_PARK_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_up && ctrl_q[32:27] == 6'h3F) |=> $stable(cnt_q[0])); // R6
  AST_PARK_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && ctrl_q[16:11] == 6'h3F) |=> $stable(cnt_q[1])); // R6
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_up |=> 32'(cnt_q[0] - $past(cnt_q[0])) <= 32'd1); // R4
  AST_STEP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> 32'(cnt_q[1] - $past(cnt_q[1])) <= 32'd1); // R4
  AST_OVF_SRC_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q[0]) |-> $past(cnt_q[0]) == 32'hFFFF_FFFF); // R8
  AST_OVF_SRC_LO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q[1]) |-> $past(cnt_q[1]) == 32'hFFFF_FFFF); // R8
  AST_CLR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (!ovf_q[0] || $past(cnt_q[0]) == 32'hFFFF_FFFF)); // R10
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[4] |-> !irq_o); // R9
endmodule

bind perf_counter_pair pcu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_sel  (reg_sel),
  .wr_half  (wr_half),
  .wr_data  (wr_data),
  .priv_ctx (priv_ctx),
  .ctrl_q   (ctrl_q),
  .cnt_q    (cnt_q),
  .ovf_q    (ovf_q),
  .irq_o    (irq_o)
);

// File: tb/perf_counter_pair_tb.sv
`timescale 1ns/1ps
module perf_counter_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [1:0]  wr_half = 2'b00;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [1:0]  priv_ctx = 2'd3;
  logic [62:0] event_in = '0;
  logic [1:0]  ovf_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;

  // reference state
  logic [32:0] m_ctrl = '0;
  logic [31:0] m_cnt [2] = '{32'd0, 32'd0};
  logic [1:0]  m_ovf = '0;

  always #2 clk = ~clk;

  perf_counter_pair u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .wr_half(wr_half), .wr_data(wr_data), .rd_data(rd_data),
    .priv_ctx(priv_ctx), .event_in(event_in), .ovf_o(ovf_o), .irq_o(irq_o)
  );

  localparam logic [32:0] CMASK = 33'h1_F801_F81E;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic ctx_on(input logic [32:0] c, input logic [1:0] x);
    case (x)
      2'd0: return c[2];
      2'd1: return c[1];
      2'd2: return c[3];
      default: return 1'b0;
    endcase
  endfunction

  // One cycle: drive, update reference, then compare after the edge
  task automatic step(input string tag, input logic wr, input logic sel,
                      input logic [1:0] half, input logic [63:0] d,
                      input logic [1:0] ctx, input logic [62:0] ev);
    logic [63:0] evx;
    logic [1:0]  setv;
    logic        en;
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; wr_half = half; wr_data = d;
    priv_ctx = ctx; event_in = ev;
    evx  = {1'b0, ev};
    en   = ctx_on(m_ctrl, ctx);
    setv = 2'b00;
    for (int i = 0; i < 2; i++) begin
      logic [5:0] code;
      logic       w, hit;
      code = (i == 0) ? m_ctrl[32:27] : m_ctrl[16:11];
      hit  = en && (code != 6'h3F) && evx[code];
      w    = wr && sel && half[1-i];
      if (w) m_cnt[i] = (i == 0) ? d[63:32] : d[31:0];
      else if (hit) begin
        if (m_cnt[i] == 32'hFFFF_FFFF) setv[i] = 1'b1;
        m_cnt[i] = m_cnt[i] + 32'd1;
      end
    end
    if (wr && !sel) begin
      m_ovf  = setv;
      m_ctrl = d[32:0] & CMASK;
    end else m_ovf = m_ovf | setv;
    @(posedge clk); #1;
    check({tag, " rd"}, rd_data, sel ? {m_cnt[0], m_cnt[1]} : {31'd0, m_ctrl});
    check({tag, " ovf"}, {62'd0, ovf_o}, {62'd0, m_ovf});
    check({tag, " irq"}, {63'd0, irq_o}, {63'd0, m_ctrl[4] && (|m_ovf)});
  endtask

  function automatic logic [63:0] mk_ctrl(input logic u, input logic s, input logic h,
                                          input logic ie, input logic [5:0] up, input logic [5:0] lo);
    logic [63:0] c;
    c = '0;
    c[2] = u; c[1] = s; c[3] = h; c[4] = ie;
    c[32:27] = up; c[16:11] = lo;
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("R1 ctrl", rd_data, 64'd0);
    check("R1 irq", {63'd0, irq_o}, 64'd0);
    check("R1 ovf", {62'd0, ovf_o}, 64'd0);
    reg_sel = 1'b1; #1;
    check("R1 cnt", rd_data, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R3: control layout and readback mask
    step("R3", 1, 0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, '0);
    check("R3 mask", rd_data, 64'h0000_0001_F801_F81E);
    // R2: half writes leave other half
    step("R2 both", 1, 1, 2'b11, 64'h1111_2222_3333_4444, 2'd3, '0);
    step("R2 lower", 1, 1, 2'b01, 64'hAAAA_AAAA_5555_6666, 2'd3, '0);
    check("R2 upper kept", rd_data, 64'h1111_2222_5555_6666);
    step("R2 upper", 1, 1, 2'b10, 64'h7777_8888_BBBB_BBBB, 2'd3, '0);
    check("R2 lower kept", rd_data, 64'h7777_8888_5555_6666);

    // R4: user context counts, event 5 upper, event 9 lower
    step("R4 cfg", 1, 0, 2'b00, mk_ctrl(1, 0, 0, 1, 6'd5, 6'd9), 2'd0, '0);
    step("R4 clr", 1, 1, 2'b11, 64'd0, 2'd0, '0);
    step("R4 up", 0, 1, 2'b00, 64'd0, 2'd0, 63'h20);
    check("R4 up count", rd_data, 64'h0000_0001_0000_0000);
    step("R4 lo", 0, 1, 2'b00, 64'd0, 2'd0, 63'h200);
    step("R4 supctx", 0, 1, 2'b00, 64'd0, 2'd1, 63'h220);
    check("R4 sup gated", rd_data, 64'h0000_0001_0000_0001);
    step("R4 nonectx", 0, 1, 2'b00, 64'd0, 2'd3, '1);

    // R5: all enables clear
    step("R5 cfg", 1, 0, 2'b00, mk_ctrl(0, 0, 0, 1, 6'd5, 6'd9), 2'd0, '0);
    for (int c = 0; c < 3; c++) step("R5", 0, 1, 2'b00, 64'd0, 2'(c), '1);
    check("R5 held", rd_data, 64'h0000_0001_0000_0001);

    // R6: parked code never counts
    step("R6 cfg", 1, 0, 2'b00, mk_ctrl(1, 1, 1, 0, 6'h3F, 6'h3F), 2'd0, '0);
    step("R6", 0, 1, 2'b00, 64'd0, 2'd0, '1);
    check("R6 held", rd_data, 64'h0000_0001_0000_0001);

    // R7: write wins over increment
    step("R7 cfg", 1, 0, 2'b00, mk_ctrl(1, 0, 0, 1, 6'd0, 6'd0), 2'd0, '0);
    step("R7", 1, 1, 2'b01, 64'h0000_0000_0000_0100, 2'd0, 63'h1);
    check("R7 prio", rd_data, 64'h0000_0002_0000_0100);

    // R8/R9/R10: wrap, interrupt, clear
    step("R8 load", 1, 1, 2'b11, 64'hFFFF_FFFF_FFFF_FFFE, 2'd0, '0);
    check("R8 no flag on load", {62'd0, ovf_o}, 64'd0);
    step("R8 wrap up", 0, 1, 2'b00, 64'd0, 2'd0, 63'h1);
    check("R8 flag up", {62'd0, ovf_o}, 64'd1);
    check("R9 irq", {63'd0, irq_o}, 64'd1);
    step("R9 mask", 1, 0, 2'b00, mk_ctrl(1, 0, 0, 0, 6'd0, 6'd0), 2'd0, 63'h1);
    check("R10 flags after lower wrap", {62'd0, ovf_o}, 64'd2);
    check("R9 irq masked", {63'd0, irq_o}, 64'd0);
    step("R10 clr", 1, 0, 2'b00, mk_ctrl(1, 0, 0, 1, 6'd0, 6'd0), 2'd0, '0);
    check("R10 cleared", {62'd0, ovf_o}, 64'd0);
    step("R10 load", 1, 1, 2'b10, 64'hFFFF_FFFF_0000_0000, 2'd0, '0);
    step("R10 same cycle", 1, 0, 2'b00, mk_ctrl(1, 0, 0, 1, 6'd0, 6'd0), 2'd0, 63'h1);
    check("R10 set wins", {62'd0, ovf_o}, 64'd1);

    // R11: period preload of 5
    step("R11 clr", 1, 0, 2'b00, mk_ctrl(0, 1, 0, 1, 6'h3F, 6'd7), 2'd1, '0);
    step("R11 load", 1, 1, 2'b01, {32'd0, 32'hFFFF_FFFB}, 2'd1, '0);
    for (int k = 0; k < 4; k++) step("R11 cnt", 0, 1, 2'b00, 64'd0, 2'd1, 63'h80);
    check("R11 early", {62'd0, ovf_o}, 64'd0);
    step("R11 cnt", 0, 1, 2'b00, 64'd0, 2'd1, 63'h80);
    check("R11 fifth", {62'd0, ovf_o}, 64'd2);

    // Random mix with near-wrap preloads
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      logic [63:0] d;
      logic wr, sel;
      r   = $urandom;
      wr  = (r[3:0] < 4'd3);
      sel = r[4] | r[5];
      d   = {$urandom, $urandom};
      if (wr && sel && r[6]) d = {32'hFFFF_FFF0 | 32'(r[11:8]), 32'hFFFF_FFF0 | 32'(r[15:12])};
      if (wr && !sel) d[32:27] = r[16] ? 6'(r[22:17] % 8) : 6'h3F;
      if (wr && !sel) d[16:11] = r[23] ? 6'(r[29:24] % 8) : 6'h3F;
      step("R4/R8/R10 rnd", wr, sel, 2'(r[31:30]), d, 2'($urandom_range(0, 3)),
           {55'd0, 8'($urandom)});
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule